// File: doc/BRIEF.md
# Bit-Addressable Nonvolatile Write Controller

This block controls a 128-bit nonvolatile array in which each bit is addressed on its own. The array is modelled here as a register bank. A command decoder upstream sends it single-cycle request strobes: erase, begin-write, read and end-write. With each strobe comes a 12-bit data field, of which the low seven bits select one bit of the array. Programming can only move a bit from 0 to 1. The only way to return bits to 0 is an erase, which clears the whole array at once.

Erase and write take effect only while both the write-enable level and the chip-select level are high. An accepted erase or write starts a programming lockout of `PROG_CYCLES` clock cycles. The default corresponds to about 50 ms at 50 MHz, and simulation uses a short value. Any request that arrives during the lockout is dropped and raises a sticky error flag. An endurance counter limits the number of accepted erases to `ERASE_LIMIT`. A read returns the addressed bit one cycle later and costs no lockout.

The controller is a four-state machine:
- **IDLE**: no write window is open.
- **OPEN**: a begin-write has completed, so a write window is open.
- **PROG_WR**: the lockout after a write.
- **PROG_ER**: the lockout after an erase.

Its transitions are as follows:
- IDLE goes to PROG_ER on an accepted erase and to PROG_WR on an accepted write.
- OPEN takes the same two transitions as IDLE. It also goes back to IDLE on an end-write.
- PROG_WR goes to OPEN when the lockout expires.
- PROG_ER goes to IDLE when the lockout expires.

When several strobes arrive in the same cycle, only one is taken. The order of priority is erase, then write, then read, then end-write.

Top module: `nvbit_ctrl`

## Requirements
- R1: After reset, `busy`, `err` and `rd_data` are 0 and every bit of `array_out` is 0.
- R2: An accepted erase clears all bits of `array_out` to 0 on the next cycle, whatever the data field holds.
- R3: An accepted begin-write sets `array_out[data_in[6:0]]` to 1 on the next cycle and leaves every other bit unchanged. Bits 11 to 7 of the data field play no part in addressing.
- R4: An erase or write is ignored unless `we` and `cs` are both 1 in the request cycle. An ignored request changes no array bit, does not raise `busy` and does not set `err`.
- R5: An accepted erase or write holds `busy` at 1 for exactly `PROG_CYCLES` cycles, starting the cycle after the request. A request is accepted in the first cycle in which `busy` is 0 again.
- R6: Once `ERASE_LIMIT` erases have been accepted since reset, any further gated erase is ignored and sets `err`.
- R7: A read that is not blocked puts `array_out[data_in[6:0]]` on `rd_data` the next cycle and does not raise `busy`. At all other times `rd_data` holds its value.
- R8: Any request strobe that arrives while `busy` is 1 is ignored. It leaves the array and `rd_data` unchanged and sets `err`, which stays at 1 until reset.
- R9: An end-write closes the write window and does not change the array or `busy`. A begin-write issued without an end-write after the previous begin-write is still applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_req | input | 1 | Erase strobe |
| write_req | input | 1 | Begin-write strobe |
| read_req | input | 1 | Read strobe |
| endw_req | input | 1 | End-write strobe |
| data_in | input | 12 | Data field; bits 6:0 select an array bit |
| we | input | 1 | Write-enable level |
| cs | input | 1 | Chip-select level |
| busy | output | 1 | Programming lockout in progress |
| rd_data | output | 1 | Bit returned by the last read |
| err | output | 1 | Sticky error flag |
| array_out | output | 128 | Array contents |

## Verification
The assertions watch every cycle for several conditions:
- the array stays frozen during a lockout and whenever the gate is low;
- an accepted erase yields an all-zero array;
- an accepted write or erase raises `busy`;
- a read never raises `busy`;
- `err` never falls;
- the erase count never exceeds its limit.

Some behaviour can only be shown by the bench's scenarios:
- that the lockout lasts exactly `PROG_CYCLES` cycles;
- that the right bit is set while the upper data bits are ignored;
- that reads return the right value;
- that an endurance refusal arrives after exactly the configured number of erases;
- that a begin-write without an end-write still lands.

// File: rtl/nvbit_pkg.sv
package nvbit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OPEN    = 2'd1,
        ST_PROG_WR = 2'd2,
        ST_PROG_ER = 2'd3
    } nv_state_t;
endpackage

// File: rtl/nvbit_timer.sv
module nvbit_timer #(
    parameter int unsigned PROG_CYCLES = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int unsigned CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start && !run_q) begin
            cnt_q <= LOAD;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run_q && (cnt_q == '0);

    // lockout counter never exceeds its load value (R5)
    assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
endmodule

// File: rtl/nvbit_wear.sv
module nvbit_wear #(
    parameter int unsigned ERASE_LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_done,
    output logic at_limit
);
    localparam int unsigned WW = $clog2(ERASE_LIMIT + 1);
    localparam logic [WW-1:0] LIM = WW'(ERASE_LIMIT);

    logic [WW-1:0] used_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      used_q <= '0;
        else if (erase_done && !at_limit) used_q <= used_q + 1'b1;
    end

    assign at_limit = (used_q >= LIM);

    // erase count is capped by the endurance limit (R6)
    assert_wear_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= LIM);
endmodule

// File: rtl/nvbit_bank.sv
module nvbit_bank #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     set,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     rd_en,
    output logic [(1<<ADDR_W)-1:0]   bits,
    output logic                     rd_bit
);
    localparam int unsigned NBITS = 1 << ADDR_W;

    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)                              bits[i] <= 1'b0;
            else if (clr)                            bits[i] <= 1'b0;
            else if (set && (addr == ADDR_W'(i)))    bits[i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_bit <= 1'b0;
        else if (rd_en) rd_bit <= bits[addr];
    end

    // an erase leaves every cell at 0 (R2)
    assert_erase_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bits == '0));
endmodule

// File: rtl/nvbit_ctrl.sv
module nvbit_ctrl
    import nvbit_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned PROG_CYCLES = 2500000,
    parameter int unsigned ERASE_LIMIT = 100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   erase_req,
    input  logic                   write_req,
    input  logic                   read_req,
    input  logic                   endw_req,
    input  logic [DATA_W-1:0]      data_in,
    input  logic                   we,
    input  logic                   cs,
    output logic                   busy,
    output logic                   rd_data,
    output logic                   err,
    output logic [(1<<ADDR_W)-1:0] array_out
);
    localparam int unsigned NBITS = 1 << ADDR_W;

    nv_state_t         state_q, state_d;
    logic              idle_ok, gate_ok, any_req, prog_done, at_limit;
    logic              do_erase, do_write, do_read, do_close, err_hit;
    logic [ADDR_W-1:0] addr;
    logic              unused_hi;

    assign addr      = data_in[ADDR_W-1:0];
    assign unused_hi = ^data_in[DATA_W-1:ADDR_W];

    // request decode with priority erase > write > read > end-write
    always_comb begin
        idle_ok  = (state_q == ST_IDLE) || (state_q == ST_OPEN);
        gate_ok  = we && cs;
        any_req  = erase_req || write_req || read_req || endw_req;
        do_erase = idle_ok && erase_req && gate_ok && !at_limit;
        do_write = idle_ok && !erase_req && write_req && gate_ok;
        do_read  = idle_ok && !erase_req && !write_req && read_req;
        do_close = idle_ok && !erase_req && !write_req && !read_req && endw_req;
        err_hit  = (!idle_ok && any_req) ||
                   (idle_ok && erase_req && gate_ok && at_limit);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_OPEN: begin
                if (do_erase)      state_d = ST_PROG_ER;
                else if (do_write) state_d = ST_PROG_WR;
                else if (do_close) state_d = ST_IDLE;
            end
            ST_PROG_WR: if (prog_done) state_d = ST_OPEN;
            ST_PROG_ER: if (prog_done) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy = (state_q == ST_PROG_WR) || (state_q == ST_PROG_ER);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (err_hit) err <= 1'b1;
    end

    nvbit_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(do_erase || do_write), .expire(prog_done)
    );

    nvbit_wear #(.ERASE_LIMIT(ERASE_LIMIT)) u_wear (
        .clk(clk), .rst_n(rst_n), .erase_done(do_erase), .at_limit(at_limit)
    );

    nvbit_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(do_erase), .set(do_write), .addr(addr),
        .rd_en(do_read), .bits(array_out), .rd_bit(rd_data)
    );

    // array frozen during lockout (R8)
    assert_frozen_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(array_out));

    // gate low: no array change (R4)
    assert_gate_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && cs) |=> $stable(array_out));

    // accepted program request starts the lockout (R5)
    assert_accept_starts_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (write_req || erase_req) && we && cs && !(erase_req && at_limit)) |=> busy);

    // read costs no lockout (R7)
    assert_read_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && read_req && !erase_req && !write_req) |=> !busy);

    // error flag is sticky (R8)
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // array width matches address space
    initial assert_width_R3: assert ($bits(array_out) == NBITS);
endmodule

// File: tb/test_nvbit_ctrl.sv
module test_nvbit_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 8;
    localparam int LIMIT      = 2;
    localparam int NV         = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         erase_req = 0, write_req = 0, read_req = 0, endw_req = 0;
    logic [11:0]  data_in = '0;
    logic         we = 0, cs = 0;
    logic         busy, rd_data, err;
    logic [127:0] array_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvbit_ctrl #(.PROG_CYCLES(PROG), .ERASE_LIMIT(LIMIT)) i_nvbit_ctrl (
        .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .write_req(write_req),
        .read_req(read_req), .endw_req(endw_req), .data_in(data_in), .we(we),
        .cs(cs), .busy(busy), .rd_data(rd_data), .err(err), .array_out(array_out)
    );

    // {req[3:0], op[2:0], data[11:0], we, cs, exp_busy, exp_rd, exp_err}
    // op: 0 none, 1 erase, 2 write, 3 read, 4 end-write
    localparam logic [23:0] TBL [0:NV-1] = '{
        {4'd3, 3'd2, 12'h005, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 write bit 5
        {4'd7, 3'd3, 12'h005, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 read bit 5
        {4'd7, 3'd3, 12'h006, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 read bit 6
        {4'd3, 3'd2, 12'hF86, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 upper bits ignored
        {4'd3, 3'd3, 12'h006, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3
        {4'd3, 3'd3, 12'h086, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 read alias
        {4'd4, 3'd2, 12'h07F, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 we low
        {4'd4, 3'd3, 12'h07F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
        {4'd4, 3'd2, 12'h07F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 cs low
        {4'd4, 3'd3, 12'h07F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
        {4'd9, 3'd4, 12'h000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R9 end-write
        {4'd9, 3'd2, 12'h07F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 write after close
        {4'd9, 3'd3, 12'h07F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R9
        {4'd4, 3'd1, 12'h000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 erase gated off
        {4'd4, 3'd3, 12'h005, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 bit survives
        {4'd2, 3'd1, 12'hABC, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R2 erase
        {4'd2, 3'd3, 12'h005, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
        {4'd2, 3'd3, 12'h07F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
        {4'd6, 3'd1, 12'h000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 second erase
        {4'd6, 3'd1, 12'h000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}  // R6 refused
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [11:0] d, input logic w, input logic c);
        data_in = d; we = w; cs = c;
        erase_req = (op == 3'd1); write_req = (op == 3'd2);
        read_req  = (op == 3'd3); endw_req  = (op == 3'd4);
        @(negedge clk);
        erase_req = 0; write_req = 0; read_req = 0; endw_req = 0; we = 0; cs = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", 128'(busy), 128'd0);
        check("R1 err", 128'(err), 128'd0);
        check("R1 rd", 128'(rd_data), 128'd0);
        check("R1 array", array_out, '0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[i][23:20], i);
            issue(TBL[i][19:17], TBL[i][16:5], TBL[i][4], TBL[i][3]);
            check({tag, " busy"}, 128'(busy), 128'(TBL[i][2]));
            check({tag, " rd"}, 128'(rd_data), 128'(TBL[i][1]));
            check({tag, " err"}, 128'(err), 128'(TBL[i][0]));
            wait_idle();
        end

        // R1: reset restores the initial state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 err after reset", 128'(err), 128'd0);
        check("R1 array after reset", array_out, '0);

        // R5: lockout length
        begin
            int n;
            n = 0;
            issue(3'd2, 12'h00A, 1'b1, 1'b1);
            while (busy) begin n++; @(negedge clk); end
            check("R5 lockout cycles", 128'(n), 128'(PROG));
            check("R3 array bit 10", array_out, 128'(1) << 10);
        end

        // R8: requests during lockout are dropped
        issue(3'd2, 12'h00B, 1'b1, 1'b1);
        issue(3'd3, 12'h00A, 1'b0, 1'b0);
        check("R8 rd held", 128'(rd_data), 128'd0);
        check("R8 err set", 128'(err), 128'd1);
        issue(3'd2, 12'h00C, 1'b1, 1'b1);
        issue(3'd1, 12'h000, 1'b1, 1'b1);
        wait_idle();
        check("R8 array", array_out, (128'(1) << 10) | (128'(1) << 11));
        check("R8 err sticky", 128'(err), 128'd1);

        // R9: back-to-back begin-writes without end-write
        issue(3'd2, 12'h020, 1'b1, 1'b1);
        wait_idle();
        issue(3'd2, 12'h021, 1'b1, 1'b1);
        wait_idle();
        check("R9 both writes", array_out,
              (128'(1) << 10) | (128'(1) << 11) | (128'(1) << 32) | (128'(1) << 33));
        issue(3'd4, 12'h000, 1'b1, 1'b1);
        check("R9 end-write no busy", 128'(busy), 128'd0);

        // R7: read of top bit after write, no lockout
        issue(3'd2, 12'h07F, 1'b1, 1'b1);
        wait_idle();
        issue(3'd3, 12'h07F, 1'b0, 1'b0);
        check("R7 rd top", 128'(rd_data), 128'd1);
        check("R7 no busy", 128'(busy), 128'd0);

        finish_run();
    end
endmodule